// File: doc/BRIEF.md
# I2C Bus Recovery Frame Generator

This block sits on the master side of an I2C bus. On request it sends a fixed recovery frame that returns every slave interface on the bus to idle. Slaves can end up in a wrong state after noise at power-up, or when the master was reset in the middle of a transfer. The frame carries no address and no data, so other devices see it as an invalid command and ignore it.

The frame has four parts, in this order:
- A Start condition. This puts any slave that is waiting to receive data back to idle.
- Nine clock pulses with SDA released. A slave that holds SDA low, for an acknowledge or for a '0' read bit, must see a not-acknowledge within these nine bits, and it then lets go of the line.
- A second Start condition. It is always sent. It stops a slave that was acknowledging a write from committing that write when the Stop arrives.
- A Stop condition. After it, the bus is free.

Both lines are driven open-drain. An enable output pulls its line low, and a deasserted enable leaves the line released. The block reads both lines back. It waits while a released SCL still reads low, to allow for clock stretching. During the nine bits it keeps a sticky flag that records whether any slave was holding SDA low. `scl_i` and `sda_i` are expected to be already synchronised to `clk`.

Every bit period has four phases of equal length. `phase_div_i` sets the length of one phase in system clocks. Values below 4 are treated as 4. The value is captured when a frame starts.

Top module: `bus_recovery_gen`

## Requirements
- R1: After reset, `scl_oe_o`, `sda_oe_o`, `busy_o`, `done_o` and `sda_held_o` are all 0.
- R2: Each frame shows the following on the bus, and nothing else:
  - exactly 11 rising edges of SCL: 9 data clocks, then one rising edge for the second Start, then one for the Stop;
  - two Start conditions (SDA falls while SCL is high);
  - one Stop condition (SDA rises while SCL is high), which comes last.
- R3: The enable outputs are active high: 1 pulls the line low. Neither enable is set while `busy_o` is 0. `sda_oe_o` stays 0 from the first SCL rising edge of the frame up to the tenth.
- R4: In a frame where no slave interferes, SDA changes exactly three times while SCL is high: the two Starts and the Stop. Every other SDA change happens while SCL is low.
- R5: One phase lasts L = max(`phase_div_i`, 4) clocks, with the value captured at the accepted start. If the clock is never stretched, `busy_o` stays high for exactly 48·L cycles. Changing `phase_div_i` during a frame has no effect on that frame.
- R6: Each clock for which SCL is released but still reads low holds the phase counter, so every stretched cycle makes the frame one cycle longer.
- R7: A one-cycle `start_i` pulse while idle sets `busy_o` in the next cycle. `done_o` is 1 for exactly one cycle, which is the first cycle in which `busy_o` is 0 again.
- R8: A `start_i` pulse while `busy_o` is 1 is ignored. The frame length stays the same, and no new frame follows.
- R9: `sda_held_o` becomes 1 if SDA reads low at the sample point of any of the nine data bits. The sample point is the last clock of the second phase, while SCL is high.
  - The flag stays 1 until the next accepted start, which clears it.
  - The flag is already 0 in the first busy cycle.
- R10: The second Start and the Stop are sent even when a slave held SDA low before the frame began. In that case the bus shows one Start and one Stop.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | One-cycle request to send a recovery frame |
| phase_div_i | input | DIV_W | Clocks per quarter-bit phase; values below 4 are treated as 4 |
| scl_i | input | 1 | SCL line level read back from the bus |
| sda_i | input | 1 | SDA line level read back from the bus |
| scl_oe_o | output | 1 | 1 pulls SCL low, 0 releases it |
| sda_oe_o | output | 1 | 1 pulls SDA low, 0 releases it |
| busy_o | output | 1 | High for the whole frame |
| done_o | output | 1 | One-cycle pulse after the Stop completes |
| sda_held_o | output | 1 | Sticky flag: SDA read low at a data-bit sample point |

## Verification
`busy_o` and a cleared `sda_held_o` are due one cycle after the start edge. `done_o` is due exactly 48·L plus the number of stretched cycles after that. The bench counts busy cycles once per clock, half a period away from the active edge, and compares the count with that sum. It checks `done_o` in the first cycle where busy is low and again one cycle later. A bus monitor samples the open-drain line levels on every falling clock edge and counts SCL edges, Starts, Stops and SDA changes while SCL is high. The bench checks these counts and the status flag once the frame has ended, so the checks do not depend on the timing inside a phase.

// File: rtl/brg_pkg.sv
package brg_pkg;

    localparam int unsigned DATA_BITS   = 9;
    localparam int unsigned NUM_SLOTS   = DATA_BITS + 3;
    localparam int unsigned SLOT_W      = $clog2(NUM_SLOTS);

    typedef logic [SLOT_W-1:0] slot_t;

    localparam slot_t SLOT_START1 = slot_t'(0);
    localparam slot_t SLOT_FIRST  = slot_t'(1);
    localparam slot_t SLOT_LAST   = slot_t'(DATA_BITS);
    localparam slot_t SLOT_START2 = slot_t'(DATA_BITS + 1);
    localparam slot_t SLOT_STOP   = slot_t'(DATA_BITS + 2);

    typedef enum logic [1:0] {
        PH_A = 2'd0,
        PH_B = 2'd1,
        PH_C = 2'd2,
        PH_D = 2'd3
    } phase_e;

    typedef struct packed {
        logic scl_low;
        logic sda_low;
    } drive_t;

    function automatic phase_e phase_next(phase_e p);
        case (p)
            PH_A:    return PH_B;
            PH_B:    return PH_C;
            PH_C:    return PH_D;
            default: return PH_A;
        endcase
    endfunction

    function automatic logic is_data_slot(slot_t s);
        return (s >= SLOT_FIRST) && (s <= SLOT_LAST);
    endfunction

    // Line pattern per slot and quarter-bit phase.
    function automatic drive_t frame_drive(slot_t s, phase_e p);
        drive_t d;
        d = '{scl_low: 1'b0, sda_low: 1'b0};
        if (s == SLOT_START1) begin
            case (p)
                PH_A: d = '{1'b0, 1'b0};
                PH_B: d = '{1'b0, 1'b1};
                PH_C: d = '{1'b1, 1'b1};
                default: d = '{1'b1, 1'b0};
            endcase
        end else if (s == SLOT_START2) begin
            case (p)
                PH_A: d = '{1'b0, 1'b0};
                PH_B: d = '{1'b0, 1'b1};
                default: d = '{1'b1, 1'b1};
            endcase
        end else if (s == SLOT_STOP) begin
            case (p)
                PH_A: d = '{1'b1, 1'b1};
                PH_B: d = '{1'b0, 1'b1};
                default: d = '{1'b0, 1'b0};
            endcase
        end else begin
            case (p)
                PH_B, PH_C: d = '{1'b0, 1'b0};
                default:    d = '{1'b1, 1'b0};
            endcase
        end
        return d;
    endfunction

endpackage

// File: rtl/brg_phase_timer.sv
module brg_phase_timer #(
    parameter int unsigned DIV_W     = 16,
    parameter int unsigned MIN_PHASE = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic             run_i,
    input  logic             stall_i,
    input  logic [DIV_W-1:0] div_i,
    output logic             tick_o
);

    localparam logic [DIV_W-1:0] MIN_DIV = DIV_W'(MIN_PHASE);
    localparam logic [DIV_W-1:0] ONE     = DIV_W'(1);

    typedef struct packed {
        logic [DIV_W-1:0] cnt;
        logic [DIV_W-1:0] lim;
    } tmr_t;

    tmr_t q, d;

    always_comb begin
        d = q;
        if (load_i) begin
            d.cnt = '0;
            d.lim = (div_i < MIN_DIV) ? (MIN_DIV - ONE) : (div_i - ONE);
        end else if (run_i && !stall_i) begin
            d.cnt = (q.cnt == q.lim) ? '0 : (q.cnt + ONE);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign tick_o = run_i && !stall_i && (q.cnt == q.lim);

    AST_TIMER_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && stall_i && !load_i) |=> $stable(q.cnt)); // R6

    AST_TIMER_TICK_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |=> !tick_o); // R5

endmodule

// File: rtl/brg_sequencer.sv
module brg_sequencer
    import brg_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic tick_i,
    input  logic sda_i,
    output logic load_o,
    output logic busy_o,
    output logic done_o,
    output logic held_o,
    output logic scl_low_o,
    output logic sda_low_o
);

    typedef struct packed {
        logic   busy;
        logic   done;
        logic   held;
        slot_t  slot;
        phase_e phase;
        drive_t drv;
    } seq_t;

    seq_t q, d;
    logic accept;

    assign accept = start_i && !q.busy;

    always_comb begin
        d      = q;
        d.done = 1'b0;
        if (!q.busy) begin
            if (start_i) begin
                d.busy  = 1'b1;
                d.held  = 1'b0;
                d.slot  = SLOT_START1;
                d.phase = PH_A;
                d.drv   = frame_drive(SLOT_START1, PH_A);
            end
        end else if (tick_i) begin
            if (is_data_slot(q.slot) && (q.phase == PH_B) && !sda_i) begin
                d.held = 1'b1;
            end
            if ((q.slot == SLOT_STOP) && (q.phase == PH_D)) begin
                d.busy = 1'b0;
                d.done = 1'b1;
                d.drv  = '{scl_low: 1'b0, sda_low: 1'b0};
            end else begin
                d.phase = phase_next(q.phase);
                if (q.phase == PH_D) begin
                    d.slot = q.slot + slot_t'(1);
                end
                d.drv = frame_drive(d.slot, d.phase);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{busy: 1'b0, done: 1'b0, held: 1'b0, slot: SLOT_START1,
                   phase: PH_A, drv: '{scl_low: 1'b0, sda_low: 1'b0}};
        end else begin
            q <= d;
        end
    end

    assign load_o    = accept;
    assign busy_o    = q.busy;
    assign done_o    = q.done;
    assign held_o    = q.held;
    assign scl_low_o = q.drv.scl_low;
    assign sda_low_o = q.drv.sda_low;

    AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        q.done |-> (!q.busy && $past(q.busy))); // R7

    AST_BUSY_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (q.busy && start_i && !tick_i) |=> ($stable(q.slot) && $stable(q.phase))); // R8

    AST_HELD_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> !q.held); // R9

    AST_HELD_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (q.held && !accept) |=> q.held); // R9

    AST_SDA_EDGE_PLACEMENT: assert property (@(posedge clk) disable iff (!rst_n)
        (q.busy && !$stable(q.drv.sda_low) && !q.drv.scl_low)
            |-> ((q.slot == SLOT_START1) || (q.slot >= SLOT_START2))); // R4

endmodule

// File: rtl/bus_recovery_gen.sv
module bus_recovery_gen #(
    parameter int unsigned DIV_W     = 16,
    parameter int unsigned MIN_PHASE = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [DIV_W-1:0] phase_div_i,
    input  logic             scl_i,
    input  logic             sda_i,
    output logic             scl_oe_o,
    output logic             sda_oe_o,
    output logic             busy_o,
    output logic             done_o,
    output logic             sda_held_o
);

    logic load;
    logic tick;
    logic stall;
    logic busy;
    logic scl_low;
    logic sda_low;

    // A released SCL that still reads low is a slave stretching the clock.
    assign stall = busy && !scl_low && !scl_i;

    brg_phase_timer #(
        .DIV_W     (DIV_W),
        .MIN_PHASE (MIN_PHASE)
    ) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (load),
        .run_i   (busy),
        .stall_i (stall),
        .div_i   (phase_div_i),
        .tick_o  (tick)
    );

    brg_sequencer u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (start_i),
        .tick_i    (tick),
        .sda_i     (sda_i),
        .load_o    (load),
        .busy_o    (busy),
        .done_o    (done_o),
        .held_o    (sda_held_o),
        .scl_low_o (scl_low),
        .sda_low_o (sda_low)
    );

    assign busy_o   = busy;
    assign scl_oe_o = scl_low;
    assign sda_oe_o = sda_low;

    AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> (!scl_oe_o && !sda_oe_o)); // R3

endmodule

// File: tb/bus_recovery_gen_bench.sv
module bus_recovery_gen_bench;

    localparam int DIV_W = 16;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start_i = 1'b0;
    logic [DIV_W-1:0] phase_div_i = DIV_W'(4);
    logic             scl_i, sda_i;
    logic             scl_oe_o, sda_oe_o, busy_o, done_o, sda_held_o;

    logic slave_sda = 1'b0;
    logic stretch   = 1'b0;

    assign scl_i = !scl_oe_o && !stretch;
    assign sda_i = !sda_oe_o && !slave_sda;

    always #2 clk = ~clk;

    bus_recovery_gen #(.DIV_W(DIV_W)) u_bus_recovery_gen (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start_i),
        .phase_div_i (phase_div_i),
        .scl_i       (scl_i),
        .sda_i       (sda_i),
        .scl_oe_o    (scl_oe_o),
        .sda_oe_o    (sda_oe_o),
        .busy_o      (busy_o),
        .done_o      (done_o),
        .sda_held_o  (sda_held_o)
    );

    int tests = 0;
    int fails = 0;
    bit finished = 1'b0;

    // bus monitor state
    bit mon_en = 1'b0;
    bit prev_scl = 1'b1, prev_sda = 1'b1;
    int rises, falls, starts, stops, hi_edges, bad_drive;
    int m_hold, s_len, r_bit, st_state, st_cnt;

    task automatic check(string req, int act, int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
        #1;
    endtask

    function automatic int exp_len(int div, int s);
        return 48 * ((div < 4) ? 4 : div) + s;
    endfunction

    function automatic int exp_starts(int m);
        return (m > 0) ? 1 : 2;
    endfunction

    function automatic int exp_hi_edges(int m);
        return (m > 0) ? 2 : 3;
    endfunction

    always @(negedge clk) begin
        if (mon_en) begin
            if (!prev_scl && scl_i) rises++;
            if (prev_scl && !scl_i) falls++;
            if (prev_scl && scl_i && prev_sda && !sda_i) starts++;
            if (prev_scl && scl_i && !prev_sda && sda_i) stops++;
            if (prev_scl && scl_i && (prev_sda != sda_i)) hi_edges++;
            if ((rises >= 1) && (rises < 10) && sda_oe_o) bad_drive++;
            prev_scl = scl_i;
            prev_sda = sda_i;
            if (slave_sda && (falls >= m_hold + 1)) slave_sda = 1'b0;
            case (st_state)
                0: if ((rises == r_bit - 1) && (falls >= r_bit) && scl_oe_o) begin
                    stretch  = 1'b1;
                    st_state = 1;
                    st_cnt   = 0;
                end
                1: if (!scl_oe_o) begin
                    st_cnt++;
                    if (st_cnt == s_len + 1) begin
                        stretch  = 1'b0;
                        st_state = 3;
                    end
                end
                default: ;
            endcase
        end
    end

    task automatic run_frame(int div, int m, int s, int r, bit extra);
        int cnt;
        int s_eff;
        s_eff = (s > 0) ? s : 0;
        step();
        rises = 0; falls = 0; starts = 0; stops = 0; hi_edges = 0; bad_drive = 0;
        m_hold = m; s_len = s_eff; r_bit = r;
        st_state = (s_eff > 0) ? 0 : 3;
        stretch = 1'b0;
        slave_sda = (m > 0);
        prev_scl = 1'b1;
        prev_sda = !slave_sda;
        phase_div_i = DIV_W'(div);
        start_i = 1'b1;
        mon_en = 1'b1;
        step();
        start_i = 1'b0;
        check("R7 busy after start", int'(busy_o), 1);
        check("R9 status cleared at start", int'(sda_held_o), 0);
        cnt = 1;
        while (cnt < 6000) begin
            if (extra && cnt == 10) begin
                start_i = 1'b1;
                phase_div_i = DIV_W'(div + 3);
            end
            if (extra && cnt == 11) start_i = 1'b0;
            step();
            if (!busy_o) break;
            cnt++;
        end
        start_i = 1'b0;
        if (cnt >= 6000) check("R7 frame hung", cnt, exp_len(div, s_eff));
        check("R5 R6 busy length", cnt, exp_len(div, s_eff));
        check("R7 done pulse", int'(done_o), 1);
        check("R9 status", int'(sda_held_o), (m > 0) ? 1 : 0);
        check("R2 scl rising edges", rises, 11);
        check("R2 R10 start conditions", starts, exp_starts(m));
        check("R2 R10 stop conditions", stops, 1);
        check("R4 sda edges while scl high", hi_edges, exp_hi_edges(m));
        check("R3 sda driven in data bits", bad_drive, 0);
        step();
        check("R7 done width", int'(done_o), 0);
        check("R8 no restart", int'(busy_o), 0);
        check("R9 status held after frame", int'(sda_held_o), (m > 0) ? 1 : 0);
        check("R3 idle releases lines", int'(scl_oe_o) + int'(sda_oe_o), 0);
        mon_en = 1'b0;
        slave_sda = 1'b0;
        stretch = 1'b0;
    endtask

    initial begin
        #(200000 * 4);
        if (!finished) begin
            fails++;
            tests++;
            $display("FAIL watchdog R7: actual %0d expected %0d", 1, 0);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd5813));
        repeat (4) step();
        check("R1 scl_oe reset", int'(scl_oe_o), 0);
        check("R1 sda_oe reset", int'(sda_oe_o), 0);
        check("R1 busy reset", int'(busy_o), 0);
        check("R1 done reset", int'(done_o), 0);
        check("R1 status reset", int'(sda_held_o), 0);
        rst_n = 1'b1;
        step();
        check("R1 idle after reset", int'(busy_o) + int'(scl_oe_o) + int'(sda_oe_o), 0);

        run_frame(4, 0, 0, 1, 1'b0);   // R2 clean frame, minimum divider
        run_frame(1, 0, 0, 1, 1'b0);   // R5 divider below minimum
        run_frame(7, 3, 0, 1, 1'b0);   // R9 R10 slave holding SDA
        run_frame(5, 0, 0, 1, 1'b0);   // R9 status cleared by next frame
        run_frame(6, 0, 9, 4, 1'b0);   // R6 stretch in bit 4
        run_frame(5, 0, 0, 1, 1'b1);   // R8 start ignored, R5 divider latched
        run_frame(4, 9, 3, 9, 1'b0);   // R10 held through all nine bits

        for (int i = 0; i < 20; i++) begin
            int div, m, s, r;
            div = int'($urandom_range(12, 1));
            m   = ($urandom_range(1, 0) == 1) ? int'($urandom_range(9, 1)) : 0;
            s   = int'($urandom_range(15, 0));
            r   = int'($urandom_range(9, 1));
            run_frame(div, m, s, r, ($urandom_range(3, 0) == 0));
        end

        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule